// File: doc/BRIEF.md
# Owner and Notification Register Bank

This block is the global control register bank of an audio streaming endpoint on a serial bus. It holds four things: the 64-bit address of the node that owns the endpoint, the most recent set of asynchronous events, the selected sample clock (source and rate), and a streaming-enable flag. A simple register bus drives the bank with one request per cycle. A request is a quadlet read, a quadlet write or a 64-bit compare/swap. A bus-reset pulse and a vector of event strobes from neighbouring logic are the other inputs.

Ownership is claimed and released only through an atomic compare/swap, and a bus reset removes it. Each time events occur, the notification register is overwritten with just the new event bits. If an owner is registered, the block raises a notification request that carries the owner address and those bits. The request is held until a stub acknowledge arrives; a later packet engine would take that acknowledge's place. The current clock selection and the enable flag are also driven out as plain outputs for the clocking and streaming logic.

Top module: `owner_notify_regbank`

## Requirements
- R1: After reset the owner holds the no-owner value 0xFFFF_0000_0000_0000, the notification and enable registers are 0, the clock-select register is 0x020C (source 0x0C internal, rate code 0x02), and no response or notification request is active.
- R2: Quadlet offsets are 0 for owner bits 63:32, 1 for owner bits 31:0, 2 for notification, 3 for clock-select and 4 for enable. A read returns the value zero-extended in rspData, and any other offset reads 0.
- R3: A compare/swap (reqKind 2) at offset 0 returns the 64-bit owner value from before the request, and it loads reqSwap only when reqCmp equals that value. A compare/swap at any other offset returns 0 and changes nothing.
- R4: Quadlet writes (reqKind 1) to offsets 0, 1, 2 and to unmapped offsets are dropped and raise no event.
- R5: A write to offset 3 stores bits 7:0 as the source and bits 15:8 as the rate code, shown on clockSource and clockRate one cycle later. Bits 31:16 are discarded. The write raises event bit 0x20 (clock accepted) on the same edge, ORed with any strobes in that cycle.
- R6: A write to offset 4 sets the enable flag to 1 for any non-zero value and to 0 for zero. The flag drives streamEnable and reads back as 1 or 0.
- R7: A busReset pulse returns the owner to the no-owner value, clears the enable flag, and drops any pending notification request. The clock-select and notification registers keep their values. busReset takes priority over a same-cycle compare/swap or enable write.
- R8: In a cycle with any event bit set (strobes 0x01 receive config, 0x02 transmit config, 0x10 current-source lock, 0x40 any-source lock, plus 0x20 from R5), the notification register is overwritten with exactly those bits. It is left unchanged in cycles with no events.
- R9: When events occur while an owner is registered, ntfValid is high on the next cycle, with ntfAddr equal to the owner and ntfData equal to the event bits.
- R10: While the owner holds the no-owner value, events raise no notification request but are still latched in the notification register.
- R11: ntfValid and its payload stay stable until ntfAck is sampled high. A newer event before the acknowledge replaces the payload and keeps the request pending.
- R12: rspValid is high exactly in the cycle after each request and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busReset | input | 1 | Bus-reset pulse |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 2 | 0 read, 1 write, 2 compare/swap |
| reqAddr | input | ADDR_W | Quadlet offset |
| reqWdata | input | 32 | Write data |
| reqCmp | input | 64 | Compare value |
| reqSwap | input | 64 | Swap value |
| rspValid | output | 1 | Response strobe |
| rspData | output | 64 | Read data or old owner value |
| evtStrobe | input | EVT_W | Event strobes |
| ntfValid | output | 1 | Notification request pending |
| ntfAddr | output | 64 | Owner address of the notification |
| ntfData | output | 32 | Event bits of the notification |
| ntfAck | input | 1 | Stub acknowledge of the notification |
| clockSource | output | 8 | Selected clock source code |
| clockRate | output | 8 | Selected rate code |
| streamEnable | output | 1 | Streaming enable flag |

## Verification
Every result is due one edge after the stimulus that causes it. A response, a register update, the clock outputs and a notification request all appear after the edge that samples the request or strobe. A dropped notification appears one edge after ntfAck. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge, so each check sees the exact cycle in which the requirement says the value is due. Hold behaviour is checked across several idle cycles in a row. The clock-select sweep walks every defined source and rate pair and checks the read-back value, the outputs and the clock-accepted notification for each one.

// File: rtl/onr_pkg.sv
package onr_pkg;
  localparam int QUAD_W = 32;
  localparam int OWNER_W = 64;
  localparam int CLKSEL_W = 16;

  localparam logic [OWNER_W-1:0] NO_OWNER = 64'hFFFF_0000_0000_0000;
  localparam logic [CLKSEL_W-1:0] CLKSEL_RESET = 16'h020C;

  localparam int OFS_OWNER_HI = 0;
  localparam int OFS_OWNER_LO = 1;
  localparam int OFS_NOTIF = 2;
  localparam int OFS_CLKSEL = 3;
  localparam int OFS_ENABLE = 4;

  localparam logic [7:0] EVT_CLK_ACCEPT = 8'h20;

  typedef enum logic [1:0] {
    REQ_READ  = 2'd0,
    REQ_WRITE = 2'd1,
    REQ_CAS   = 2'd2
  } reqKind_e;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_OWNER_HI,
    RD_OWNER_LO,
    RD_NOTIF,
    RD_CLKSEL,
    RD_ENABLE,
    RD_CAS
  } rdSel_e;

  typedef struct packed {
    logic   loadClk;
    logic   loadEnable;
    logic   enableVal;
    logic   swapOwner;
    logic   ownerClear;
    logic   loadNotif;
    logic   loadNtf;
    logic   rspLoad;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/onr_ctrl.sv
module onr_ctrl
  import onr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int EVT_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busReset,
  input  logic                 reqValid,
  input  logic [1:0]           reqKind,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [QUAD_W-1:0]    reqWdata,
  input  logic [EVT_W-1:0]     evtStrobe,
  input  logic                 ntfAck,
  input  logic                 ownerMatch,
  input  logic                 ownerFree,
  output strobe_t              st,
  output logic [EVT_W-1:0]     evtNow,
  output logic                 ntfValid
);
  localparam logic [EVT_W-1:0] CLK_EVT = EVT_W'(EVT_CLK_ACCEPT);

  logic isRead, isWrite, isCas;
  logic hitOwnerHi, hitOwnerLo, hitNotif, hitClk, hitEnable;
  logic ntfValidQ;

  assign isRead  = reqValid && (reqKind == REQ_READ);
  assign isWrite = reqValid && (reqKind == REQ_WRITE);
  assign isCas   = reqValid && (reqKind == REQ_CAS);

  assign hitOwnerHi = (reqAddr == ADDR_W'(OFS_OWNER_HI));
  assign hitOwnerLo = (reqAddr == ADDR_W'(OFS_OWNER_LO));
  assign hitNotif   = (reqAddr == ADDR_W'(OFS_NOTIF));
  assign hitClk     = (reqAddr == ADDR_W'(OFS_CLKSEL));
  assign hitEnable  = (reqAddr == ADDR_W'(OFS_ENABLE));

  always_comb begin
    st = '0;
    st.loadClk    = isWrite && hitClk;
    st.loadEnable = isWrite && hitEnable && !busReset;
    st.enableVal  = |reqWdata;
    st.swapOwner  = isCas && hitOwnerHi && ownerMatch && !busReset;
    st.ownerClear = busReset;
    st.rspLoad    = reqValid;
    evtNow        = evtStrobe | (st.loadClk ? CLK_EVT : '0);
    st.loadNotif  = |evtNow;
    st.loadNtf    = (|evtNow) && !ownerFree && !busReset;
    st.rdSel      = RD_ZERO;
    if (isCas && hitOwnerHi) begin
      st.rdSel = RD_CAS;
    end else if (isRead) begin
      if (hitOwnerHi)      st.rdSel = RD_OWNER_HI;
      else if (hitOwnerLo) st.rdSel = RD_OWNER_LO;
      else if (hitNotif)   st.rdSel = RD_NOTIF;
      else if (hitClk)     st.rdSel = RD_CLKSEL;
      else if (hitEnable)  st.rdSel = RD_ENABLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ntfValidQ <= 1'b0;
    end else if (busReset) begin
      ntfValidQ <= 1'b0;
    end else if (st.loadNtf) begin
      ntfValidQ <= 1'b1;
    end else if (ntfAck) begin
      ntfValidQ <= 1'b0;
    end
  end

  assign ntfValid = ntfValidQ;
endmodule

// File: rtl/onr_dpath.sv
module onr_dpath
  import onr_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              st,
  input  logic [OWNER_W-1:0]   reqCmp,
  input  logic [OWNER_W-1:0]   reqSwap,
  input  logic [CLKSEL_W-1:0]  clkWdata,
  input  logic [EVT_W-1:0]     evtNow,
  output logic                 ownerMatch,
  output logic                 ownerFree,
  output logic                 rspValid,
  output logic [OWNER_W-1:0]   rspData,
  output logic [OWNER_W-1:0]   ntfAddr,
  output logic [QUAD_W-1:0]    ntfData,
  output logic [7:0]           clockSource,
  output logic [7:0]           clockRate,
  output logic                 streamEnable
);
  logic [OWNER_W-1:0]  ownerQ;
  logic [EVT_W-1:0]    notifQ;
  logic [CLKSEL_W-1:0] clkSelQ;
  logic                enableQ;
  logic [OWNER_W-1:0]  ntfAddrQ;
  logic [EVT_W-1:0]    ntfDataQ;
  logic                rspValidQ;
  logic [OWNER_W-1:0]  rspDataQ;
  logic [OWNER_W-1:0]  rdMux;

  assign ownerMatch = (reqCmp == ownerQ);
  assign ownerFree  = (ownerQ == NO_OWNER);

  always_comb begin
    unique case (st.rdSel)
      RD_OWNER_HI: rdMux = {32'b0, ownerQ[63:32]};
      RD_OWNER_LO: rdMux = {32'b0, ownerQ[31:0]};
      RD_NOTIF:    rdMux = OWNER_W'(notifQ);
      RD_CLKSEL:   rdMux = OWNER_W'(clkSelQ);
      RD_ENABLE:   rdMux = OWNER_W'(enableQ);
      RD_CAS:      rdMux = ownerQ;
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerQ <= NO_OWNER;
    end else if (st.ownerClear) begin
      ownerQ <= NO_OWNER;
    end else if (st.swapOwner) begin
      ownerQ <= reqSwap;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= 1'b0;
    end else if (st.ownerClear) begin
      enableQ <= 1'b0;
    end else if (st.loadEnable) begin
      enableQ <= st.enableVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSelQ <= CLKSEL_RESET;
    end else if (st.loadClk) begin
      clkSelQ <= clkWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      notifQ <= '0;
    end else if (st.loadNotif) begin
      notifQ <= evtNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ntfAddrQ <= '0;
      ntfDataQ <= '0;
    end else if (st.loadNtf) begin
      ntfAddrQ <= ownerQ;
      ntfDataQ <= evtNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValidQ <= 1'b0;
      rspDataQ  <= '0;
    end else begin
      rspValidQ <= st.rspLoad;
      rspDataQ  <= st.rspLoad ? rdMux : '0;
    end
  end

  assign rspValid     = rspValidQ;
  assign rspData      = rspDataQ;
  assign ntfAddr      = ntfAddrQ;
  assign ntfData      = QUAD_W'(ntfDataQ);
  assign clockSource  = clkSelQ[7:0];
  assign clockRate    = clkSelQ[15:8];
  assign streamEnable = enableQ;
endmodule

// File: rtl/owner_notify_regbank.sv
module owner_notify_regbank
  import onr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int EVT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReset,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic [63:0]       reqCmp,
  input  logic [63:0]       reqSwap,
  output logic              rspValid,
  output logic [63:0]       rspData,
  input  logic [EVT_W-1:0]  evtStrobe,
  output logic              ntfValid,
  output logic [63:0]       ntfAddr,
  output logic [31:0]       ntfData,
  input  logic              ntfAck,
  output logic [7:0]        clockSource,
  output logic [7:0]        clockRate,
  output logic              streamEnable
);
  strobe_t          st;
  logic [EVT_W-1:0] evtNow;
  logic             ownerMatch;
  logic             ownerFree;

  onr_ctrl #(.ADDR_W(ADDR_W), .EVT_W(EVT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busReset(busReset),
    .reqValid(reqValid), .reqKind(reqKind), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .evtStrobe(evtStrobe), .ntfAck(ntfAck),
    .ownerMatch(ownerMatch), .ownerFree(ownerFree),
    .st(st), .evtNow(evtNow), .ntfValid(ntfValid)
  );

  onr_dpath #(.EVT_W(EVT_W)) dpath_i (
    .clk(clk), .rstN(rstN), .st(st),
    .reqCmp(reqCmp), .reqSwap(reqSwap), .clkWdata(reqWdata[15:0]),
    .evtNow(evtNow), .ownerMatch(ownerMatch), .ownerFree(ownerFree),
    .rspValid(rspValid), .rspData(rspData),
    .ntfAddr(ntfAddr), .ntfData(ntfData),
    .clockSource(clockSource), .clockRate(clockRate),
    .streamEnable(streamEnable)
  );
endmodule

// File: rtl/onr_checker.sv
module onr_checker #(
  parameter int ADDR_W = 4,
  parameter int EVT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReset,
  input logic              reqValid,
  input logic [1:0]        reqKind,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [31:0]       reqWdata,
  input logic              rspValid,
  input logic [EVT_W-1:0]  evtStrobe,
  input logic              ntfValid,
  input logic [63:0]       ntfAddr,
  input logic [31:0]       ntfData,
  input logic              ntfAck,
  input logic [7:0]        clockSource,
  input logic [7:0]        clockRate,
  input logic              streamEnable
);
  logic clkWr, enWr, evtAny;
  assign clkWr  = reqValid && reqKind == 2'd1 && reqAddr == ADDR_W'(3);
  assign enWr   = reqValid && reqKind == 2'd1 && reqAddr == ADDR_W'(4);
  assign evtAny = (|evtStrobe) || clkWr;

  assert_rsp_follows_req_R12: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_no_spurious_rsp_R12: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  assert_reset_clears_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> !streamEnable);
  assert_reset_drops_ntf_R7: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> !ntfValid);
  assert_ntf_has_owner_R10: assert property (@(posedge clk) disable iff (!rstN)
    ntfValid |-> ntfAddr != 64'hFFFF_0000_0000_0000);
  assert_ntf_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ntfValid && !ntfAck && !busReset && !evtAny) |=>
      (ntfValid && $stable(ntfData) && $stable(ntfAddr)));
  assert_clk_write_lands_R5: assert property (@(posedge clk) disable iff (!rstN)
    clkWr |=> (clockSource == $past(reqWdata[7:0]) && clockRate == $past(reqWdata[15:8])));
  assert_enable_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enWr && !busReset) |=> (streamEnable == ($past(reqWdata) != 32'd0)));
endmodule

bind owner_notify_regbank onr_checker #(.ADDR_W(ADDR_W), .EVT_W(EVT_W)) chk_i (
  .clk(clk), .rstN(rstN), .busReset(busReset), .reqValid(reqValid),
  .reqKind(reqKind), .reqAddr(reqAddr), .reqWdata(reqWdata),
  .rspValid(rspValid), .evtStrobe(evtStrobe), .ntfValid(ntfValid),
  .ntfAddr(ntfAddr), .ntfData(ntfData), .ntfAck(ntfAck),
  .clockSource(clockSource), .clockRate(clockRate),
  .streamEnable(streamEnable)
);

// File: tb/owner_notify_regbank_tb_top.sv
module owner_notify_regbank_tb_top;
  localparam logic [63:0] NO_OWN = 64'hFFFF_0000_0000_0000;
  localparam logic [63:0] OWN_A  = 64'h00C1_0000_F000_0040;
  localparam logic [63:0] OWN_B  = 64'h00C2_1234_5678_9ABC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReset = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [3:0]  reqAddr = 4'd0;
  logic [31:0] reqWdata = 32'd0;
  logic [63:0] reqCmp = 64'd0;
  logic [63:0] reqSwap = 64'd0;
  logic        rspValid;
  logic [63:0] rspData;
  logic [7:0]  evtStrobe = 8'd0;
  logic        ntfValid;
  logic [63:0] ntfAddr;
  logic [31:0] ntfData;
  logic        ntfAck = 1'b0;
  logic [7:0]  clockSource;
  logic [7:0]  clockRate;
  logic        streamEnable;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [63:0] rd;

  always #4 clk = ~clk;

  owner_notify_regbank dut_i (
    .clk(clk), .rstN(rstN), .busReset(busReset), .reqValid(reqValid),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqCmp(reqCmp), .reqSwap(reqSwap), .rspValid(rspValid),
    .rspData(rspData), .evtStrobe(evtStrobe), .ntfValid(ntfValid),
    .ntfAddr(ntfAddr), .ntfData(ntfData), .ntfAck(ntfAck),
    .clockSource(clockSource), .clockRate(clockRate),
    .streamEnable(streamEnable)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReq(input logic [1:0] kind, input logic [3:0] addr,
                       input logic [31:0] wd, input logic [63:0] cmp,
                       input logic [63:0] swp, output logic [63:0] data);
    @(negedge clk);
    reqValid = 1'b1; reqKind = kind; reqAddr = addr;
    reqWdata = wd; reqCmp = cmp; reqSwap = swp;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check("R12 rspValid", {63'd0, rspValid}, 64'd1);
    data = rspData;
  endtask

  task automatic readChk(input logic [3:0] addr, input logic [63:0] exp, input string tag);
    logic [63:0] d;
    doReq(2'd0, addr, 32'd0, 64'd0, 64'd0, d);
    check(tag, d, exp);
  endtask

  task automatic writeQ(input logic [3:0] addr, input logic [31:0] wd);
    logic [63:0] d;
    doReq(2'd1, addr, wd, 64'd0, 64'd0, d);
  endtask

  task automatic pulseEvt(input logic [7:0] v);
    @(negedge clk);
    evtStrobe = v;
    @(posedge clk);
    @(negedge clk);
    evtStrobe = 8'd0;
  endtask

  task automatic expectNtf(input logic [31:0] dat, input logic [63:0] addr, input string tag);
    check({tag, " ntfValid"}, {63'd0, ntfValid}, 64'd1);
    check({tag, " ntfData"}, {32'd0, ntfData}, {32'd0, dat});
    check({tag, " ntfAddr"}, ntfAddr, addr);
    ntfAck = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ntfAck = 1'b0;
    check("R11 ntf dropped after ack", {63'd0, ntfValid}, 64'd0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 streamEnable", {63'd0, streamEnable}, 64'd0);
    check("R1 ntfValid", {63'd0, ntfValid}, 64'd0);
    check("R1 rspValid", {63'd0, rspValid}, 64'd0);
    check("R1 clockSource", {56'd0, clockSource}, 64'h0C);
    check("R1 clockRate", {56'd0, clockRate}, 64'h02);
    readChk(4'd0, 64'hFFFF_0000, "R1 owner hi");
    readChk(4'd1, 64'd0, "R1 owner lo");
    readChk(4'd2, 64'd0, "R1 notif");
    readChk(4'd3, 64'h020C, "R1 clksel");
    readChk(4'd4, 64'd0, "R1 enable");

    // R2 unmapped offsets read zero
    for (int a = 5; a < 16; a++) readChk(4'(a), 64'd0, "R2 unmapped read");

    // R10 events latched with no owner, no request
    pulseEvt(8'h11);
    check("R10 no ntf without owner", {63'd0, ntfValid}, 64'd0);
    readChk(4'd2, 64'h11, "R10 notif latched");
    pulseEvt(8'h02);
    readChk(4'd2, 64'h02, "R8 overwrite not accumulate");
    readChk(4'd2, 64'h02, "R8 unchanged without events");

    // R3 compare/swap
    doReq(2'd2, 4'd0, 32'd0, 64'd0, OWN_A, rd);
    check("R3 cas miss returns old", rd, NO_OWN);
    readChk(4'd0, 64'hFFFF_0000, "R3 cas miss keeps owner");
    doReq(2'd2, 4'd1, 32'd0, NO_OWN, OWN_A, rd);
    check("R3 cas wrong offset returns 0", rd, 64'd0);
    readChk(4'd0, 64'hFFFF_0000, "R3 cas wrong offset no change");
    doReq(2'd2, 4'd0, 32'd0, NO_OWN, OWN_A, rd);
    check("R3 cas hit returns old", rd, NO_OWN);
    readChk(4'd0, {32'd0, OWN_A[63:32]}, "R3 owner hi after swap");
    readChk(4'd1, {32'd0, OWN_A[31:0]}, "R3 owner lo after swap");
    doReq(2'd2, 4'd0, 32'd0, OWN_A, OWN_B, rd);
    check("R3 second cas returns old", rd, OWN_A);
    readChk(4'd0, {32'd0, OWN_B[63:32]}, "R3 owner hi replaced");

    // R4 dropped writes
    writeQ(4'd0, 32'hDEAD_BEEF);
    writeQ(4'd1, 32'hDEAD_BEEF);
    writeQ(4'd2, 32'h0000_00FF);
    writeQ(4'd9, 32'h0000_0001);
    check("R4 no event from dropped writes", {63'd0, ntfValid}, 64'd0);
    readChk(4'd0, {32'd0, OWN_B[63:32]}, "R4 owner hi kept");
    readChk(4'd1, {32'd0, OWN_B[31:0]}, "R4 owner lo kept");
    readChk(4'd2, 64'h02, "R4 notif kept");
    readChk(4'd9, 64'd0, "R4 unmapped still zero");

    // R9 and R8 over all combinations of the strobe events
    for (int i = 1; i < 16; i++) begin
      logic [7:0] v;
      v = (i[0] ? 8'h01 : 8'h00) | (i[1] ? 8'h02 : 8'h00) |
          (i[2] ? 8'h10 : 8'h00) | (i[3] ? 8'h40 : 8'h00);
      pulseEvt(v);
      expectNtf({24'd0, v}, OWN_B, "R9 event notify");
      readChk(4'd2, {56'd0, v}, "R8 notif equals event");
    end

    // R11 hold until ack, newer event replaces payload
    pulseEvt(8'h01);
    for (int k = 0; k < 5; k++) begin
      check("R11 held valid", {63'd0, ntfValid}, 64'd1);
      check("R11 held data", {32'd0, ntfData}, 64'h01);
      @(negedge clk);
    end
    pulseEvt(8'h40);
    expectNtf(32'h40, OWN_B, "R11 replaced payload");

    // R5 clock-select sweep over all sources and rates
    for (int s = 0; s <= 12; s++) begin
      for (int r = 0; r <= 10; r++) begin
        writeQ(4'd3, {16'hA5A5, 8'(r), 8'(s)});
        check("R5 clockSource", {56'd0, clockSource}, 64'(s));
        check("R5 clockRate", {56'd0, clockRate}, 64'(r));
        expectNtf(32'h20, OWN_B, "R5 clock accepted");
        readChk(4'd3, {48'd0, 8'(r), 8'(s)}, "R5 clksel readback");
      end
    end

    // R5 clock write combined with a strobe in the same cycle
    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'd1; reqAddr = 4'd3; reqWdata = 32'h0000_0402;
    evtStrobe = 8'h01;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; evtStrobe = 8'h00;
    expectNtf(32'h21, OWN_B, "R5 merged events");
    readChk(4'd2, 64'h21, "R8 merged notif");

    // R6 enable
    writeQ(4'd4, 32'h8000_0000);
    check("R6 enable on", {63'd0, streamEnable}, 64'd1);
    readChk(4'd4, 64'd1, "R6 enable reads 1");
    writeQ(4'd4, 32'd0);
    check("R6 enable off", {63'd0, streamEnable}, 64'd0);
    readChk(4'd4, 64'd0, "R6 enable reads 0");
    writeQ(4'd4, 32'd1);
    check("R6 enable on again", {63'd0, streamEnable}, 64'd1);

    // R7 bus reset
    pulseEvt(8'h10);
    check("R7 ntf pending before reset", {63'd0, ntfValid}, 64'd1);
    @(negedge clk);
    busReset = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busReset = 1'b0;
    check("R7 ntf dropped", {63'd0, ntfValid}, 64'd0);
    check("R7 enable cleared", {63'd0, streamEnable}, 64'd0);
    readChk(4'd0, 64'hFFFF_0000, "R7 owner hi no-owner");
    readChk(4'd1, 64'd0, "R7 owner lo no-owner");
    readChk(4'd3, 64'h0402, "R7 clksel kept");
    readChk(4'd2, 64'h10, "R7 notif kept");
    pulseEvt(8'h02);
    check("R10 no ntf after reset", {63'd0, ntfValid}, 64'd0);
    readChk(4'd2, 64'h02, "R10 notif latched after reset");

    finishRun();
  end
endmodule